// File: doc/BRIEF.md
# Event Redirect Unit

This unit sits next to a simple in-order core and decides, at each instruction boundary, whether fetch must leave the sequential path. The core raises `instr_done` when an instruction retires and presents that instruction's PC together with any internal event it raised: an arithmetic overflow or a page fault. A separate line carries an I/O-completion interrupt. At a boundary, the events act as an implied multi-way branch. If any event is taken, the unit stores the retiring PC in its saved-PC register and records an encoded cause. It then reads the handler address for that cause from a small table and issues a one-cycle redirect carrying that address.

A return request from the running handler redirects fetch to the saved PC plus 4 and ends the handler. While a handler runs, the external interrupt is held off, but internal events still enter. The handler table is loaded through a simple write port and clears to zero on reset.

Top module: `evt_redirect_unit`

## Requirements
- R1: After synchronous reset, `redirect_vld`, `in_handler`, `saved_pc` and `cause` are all zero, and every handler-table entry is zero. An event taken straight after reset therefore redirects to address 0.
- R2: Event inputs are sampled only on a clock edge where `instr_done` is 1. Events at any other edge produce no redirect and leave `saved_pc` and `cause` unchanged.
- R3: When an event is taken at an edge, `redirect_vld` is 1 in the following cycle. In that cycle `redirect_pc` equals the table entry for the cause, `saved_pc` equals `cur_pc` from that edge, and `in_handler` is 1.
- R4: Simultaneous events are ranked page fault, then overflow, then interrupt. The cause codes are 2 for page fault, 1 for overflow and 0 for interrupt.
- R5: A write on the table port (`tbl_we`) at an edge stores `tbl_data` at entry `tbl_idx`, where indices 0 to 2 match the cause codes. Index 3 writes nothing. A lookup at the same edge as a write to the same entry returns the old content.
- R6: While `in_handler` is 1, an interrupt has no effect. An overflow or a page fault is still taken and overwrites `saved_pc` and `cause`.
- R7: A return request (`ret_req`) at an edge with `in_handler` 1 gives a redirect to `saved_pc + 4` in the next cycle and clears `in_handler`. A return request with `in_handler` 0 does nothing.
- R8: If an event is taken at the same edge as a return request, the event entry happens, the return is dropped, and `in_handler` stays 1.
- R9: `redirect_vld` is a single-cycle pulse per taken event or accepted return. It is 0 in any cycle that follows an edge with neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | Instruction retires this cycle (event sampling point) |
| cur_pc | input | PC_W | PC of the retiring instruction |
| ovf_evt | input | 1 | Arithmetic overflow raised by the retiring instruction |
| pgf_evt | input | 1 | Page fault raised by the retiring instruction |
| io_irq | input | 1 | External I/O-completion interrupt |
| ret_req | input | 1 | Return-from-handler request |
| tbl_we | input | 1 | Handler table write enable |
| tbl_idx | input | CIDX_W | Handler table entry to write |
| tbl_data | input | PC_W | Handler address to write |
| redirect_vld | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | PC_W | Redirect target |
| saved_pc | output | PC_W | Saved PC of the instruction that raised the last event |
| cause | output | CIDX_W | Encoded cause of the last taken event |
| in_handler | output | 1 | A handler is active |

## Verification
Event entry and return can fall on the same edge. They compete for the single redirect register and for the `in_handler` flag. The bench provokes this in two ways. It drives `ret_req` while the handler is active and raises an overflow at the same edge. It also leaves such collisions to the random mix, where every input toggles freely. The bench judges the result by requiring the entry target, the new saved PC and a still-set `in_handler` in the following cycle. A second return must then land on the new saved PC plus 4.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NUM_CAUSES = 3;

  typedef enum logic [1:0] {
    CAUSE_IRQ = 2'd0,
    CAUSE_OVF = 2'd1,
    CAUSE_PGF = 2'd2
  } cause_e;
endpackage

// File: rtl/evt_prio.sv
module evt_prio
  import evt_pkg::*;
(
  input  logic   sample,
  input  logic   pgf,
  input  logic   ovf,
  input  logic   irq,
  input  logic   irq_mask,
  output logic   take,
  output cause_e sel
);
  always_comb begin
    take = 1'b0;
    sel  = CAUSE_IRQ;
    if (sample) begin
      if (pgf) begin
        take = 1'b1;
        sel  = CAUSE_PGF;
      end else if (ovf) begin
        take = 1'b1;
        sel  = CAUSE_OVF;
      end else if (irq && !irq_mask) begin
        take = 1'b1;
        sel  = CAUSE_IRQ;
      end
    end
  end
endmodule

// File: rtl/hdl_table.sv
module hdl_table #(
  parameter int W  = 32,
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] ent [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)
        ent[g] <= '0;
      else if (we && widx == IW'(g))
        ent[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++)
      if (ridx == IW'(i)) rdata = ent[i];
  end
endmodule

// File: rtl/evt_redirect_unit.sv
module evt_redirect_unit
  import evt_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int CIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_done,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic              ovf_evt,
  input  logic              pgf_evt,
  input  logic              io_irq,
  input  logic              ret_req,
  input  logic              tbl_we,
  input  logic [CIDX_W-1:0] tbl_idx,
  input  logic [PC_W-1:0]   tbl_data,
  output logic              redirect_vld,
  output logic [PC_W-1:0]   redirect_pc,
  output logic [PC_W-1:0]   saved_pc,
  output logic [CIDX_W-1:0] cause,
  output logic              in_handler
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic            take;
  cause_e          sel;
  logic [PC_W-1:0] hdl_addr;
  logic            ret_ok;

  evt_prio u_prio (
    .sample   (instr_done),
    .pgf      (pgf_evt),
    .ovf      (ovf_evt),
    .irq      (io_irq),
    .irq_mask (in_handler),
    .take     (take),
    .sel      (sel)
  );

  hdl_table #(.W(PC_W), .N(NUM_CAUSES), .IW(CIDX_W)) u_tbl (
    .clk   (clk),
    .rst   (rst),
    .we    (tbl_we),
    .widx  (tbl_idx),
    .wdata (tbl_data),
    .ridx  (CIDX_W'(sel)),
    .rdata (hdl_addr)
  );

  assign ret_ok = ret_req && in_handler && !take;

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_vld <= 1'b0;
      redirect_pc  <= '0;
      saved_pc     <= '0;
      cause        <= '0;
      in_handler   <= 1'b0;
    end else begin
      redirect_vld <= 1'b0;
      if (take) begin
        saved_pc     <= cur_pc;
        cause        <= CIDX_W'(sel);
        in_handler   <= 1'b1;
        redirect_vld <= 1'b1;
        redirect_pc  <= hdl_addr;
      end else if (ret_ok) begin
        in_handler   <= 1'b0;
        redirect_vld <= 1'b1;
        redirect_pc  <= saved_pc + STEP;
      end
    end
  end
endmodule

// File: rtl/evt_redirect_unit_chk.sv
module evt_redirect_unit_chk #(
  parameter int PC_W   = 32,
  parameter int CIDX_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_done,
  input logic [PC_W-1:0]   cur_pc,
  input logic              ovf_evt,
  input logic              pgf_evt,
  input logic              io_irq,
  input logic              ret_req,
  input logic              redirect_vld,
  input logic [PC_W-1:0]   redirect_pc,
  input logic [PC_W-1:0]   saved_pc,
  input logic [CIDX_W-1:0] cause,
  input logic              in_handler
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!redirect_vld && !in_handler && cause == '0));

  a_r2_no_sample: assert property (@(posedge clk) disable iff (rst)
    (!instr_done && !ret_req) |=> !redirect_vld);

  a_r3_entry: assert property (@(posedge clk) disable iff (rst)
    (instr_done && (pgf_evt || ovf_evt)) |=>
      (redirect_vld && in_handler && saved_pc == $past(cur_pc)));

  a_r4_pgf_first: assert property (@(posedge clk) disable iff (rst)
    (instr_done && pgf_evt) |=> (cause == CIDX_W'(2)));

  a_r4_ovf_next: assert property (@(posedge clk) disable iff (rst)
    (instr_done && ovf_evt && !pgf_evt) |=> (cause == CIDX_W'(1)));

  a_r6_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (in_handler && !ret_req && !pgf_evt && !ovf_evt) |=> !redirect_vld);

  a_r7_return: assert property (@(posedge clk) disable iff (rst)
    (ret_req && in_handler && !(instr_done && (pgf_evt || ovf_evt))) |=>
      (redirect_vld && !in_handler && redirect_pc == $past(saved_pc) + PC_W'(4)));

  a_r8_entry_wins: assert property (@(posedge clk) disable iff (rst)
    (ret_req && instr_done && (pgf_evt || ovf_evt)) |=> in_handler);
endmodule

bind evt_redirect_unit evt_redirect_unit_chk #(.PC_W(PC_W), .CIDX_W(CIDX_W)) u_chk (
  .clk(clk), .rst(rst), .instr_done(instr_done), .cur_pc(cur_pc),
  .ovf_evt(ovf_evt), .pgf_evt(pgf_evt), .io_irq(io_irq), .ret_req(ret_req),
  .redirect_vld(redirect_vld), .redirect_pc(redirect_pc), .saved_pc(saved_pc),
  .cause(cause), .in_handler(in_handler)
);

// File: tb/evt_redirect_unit_test.sv
module evt_redirect_unit_test;
  localparam int PC_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instr_done = 0, ovf_evt = 0, pgf_evt = 0, io_irq = 0, ret_req = 0, tbl_we = 0;
  logic [PC_W-1:0] cur_pc = '0, tbl_data = '0;
  logic [1:0] tbl_idx = '0;
  logic redirect_vld, in_handler;
  logic [PC_W-1:0] redirect_pc, saved_pc;
  logic [1:0] cause;

  int n_chk = 0, n_bad = 0;
  logic [PC_W-1:0] m_tbl [3];
  logic [PC_W-1:0] m_epc;
  logic [1:0] m_cause;
  logic m_act;

  always #10 clk = ~clk;

  evt_redirect_unit #(.PC_W(PC_W), .CIDX_W(2)) uut (
    .clk(clk), .rst(rst), .instr_done(instr_done), .cur_pc(cur_pc),
    .ovf_evt(ovf_evt), .pgf_evt(pgf_evt), .io_irq(io_irq), .ret_req(ret_req),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
    .redirect_vld(redirect_vld), .redirect_pc(redirect_pc), .saved_pc(saved_pc),
    .cause(cause), .in_handler(in_handler)
  );

  function automatic logic [1:0] exp_code(input logic p, input logic o);
    return p ? 2'd2 : (o ? 2'd1 : 2'd0);
  endfunction

  task automatic check(input string tag, input logic ev, input logic [PC_W-1:0] epc_v,
                       input logic [PC_W-1:0] epc, input logic [1:0] ec, input logic ea);
    n_chk++;
    if (redirect_vld !== ev || (ev && redirect_pc !== epc_v) || saved_pc !== epc ||
        cause !== ec || in_handler !== ea) begin
      n_bad++;
      $display("FAIL %s: got vld=%0b pc=%h saved=%h cause=%0d act=%0b exp vld=%0b pc=%h saved=%h cause=%0d act=%0b",
               tag, redirect_vld, redirect_pc, saved_pc, cause, in_handler,
               ev, epc_v, epc, ec, ea);
    end
  endtask

  task automatic step(input string tag, input logic d, input logic o, input logic p,
                      input logic q, input logic r, input logic [PC_W-1:0] pc,
                      input logic w, input logic [1:0] wi, input logic [PC_W-1:0] wd);
    logic tk;
    logic [1:0] ec;
    logic ev;
    logic [PC_W-1:0] evpc;
    instr_done = d; ovf_evt = o; pgf_evt = p; io_irq = q; ret_req = r; cur_pc = pc;
    tbl_we = w; tbl_idx = wi; tbl_data = wd;
    tk = d && (p || o || (q && !m_act));
    ec = exp_code(p, o);
    ev = 1'b0; evpc = '0;
    if (tk) begin
      ev = 1'b1; evpc = m_tbl[ec]; m_epc = pc; m_cause = ec; m_act = 1'b1;
    end else if (r && m_act) begin
      ev = 1'b1; evpc = m_epc + 32'd4; m_act = 1'b0;
    end
    if (w && wi != 2'd3) m_tbl[wi] = wd;
    @(posedge clk);
    @(negedge clk);
    check(tag, ev, evpc, m_epc, m_cause, m_act);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got running exp finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) m_tbl[i] = '0;
    m_epc = '0; m_cause = '0; m_act = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset", 1'b0, '0, '0, 2'd0, 1'b0);
    // R1: empty table redirects to zero
    step("R1 zero table", 1, 1, 0, 0, 0, 32'h10, 0, 0, 0);
    step("R7 leave", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    // R5: table load, index 3 ignored
    step("R5 w0", 0, 0, 0, 0, 0, 0, 1, 2'd0, 32'h100);
    step("R5 w1", 0, 0, 0, 0, 0, 0, 1, 2'd1, 32'h200);
    step("R5 w2", 0, 0, 0, 0, 0, 0, 1, 2'd2, 32'h300);
    step("R5 w3 ignored", 0, 0, 0, 0, 0, 0, 1, 2'd3, 32'hDEAD);
    step("R3 irq entry", 1, 0, 0, 1, 0, 32'h40, 0, 0, 0);
    step("R9 pulse ends", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R6 irq masked", 1, 0, 0, 1, 0, 32'h44, 0, 0, 0);
    step("R6 ovf nested", 1, 1, 0, 0, 0, 32'h104, 0, 0, 0);
    step("R7 return", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    step("R7 idle return ignored", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    step("R2 no boundary", 0, 1, 1, 1, 0, 32'h60, 0, 0, 0);
    step("R4 all three", 1, 1, 1, 1, 0, 32'h50, 0, 0, 0);
    step("R8 entry beats return", 1, 1, 0, 0, 1, 32'h308, 0, 0, 0);
    step("R8 later return", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    step("R5 write vs lookup", 1, 0, 1, 0, 0, 32'h70, 1, 2'd2, 32'h440);
    step("R5 new value", 1, 0, 1, 0, 0, 32'h74, 0, 0, 0);
    step("R7 back", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    step("R4 ovf over irq", 1, 1, 0, 1, 0, 32'h80, 0, 0, 0);
    process::self().srandom(32'd352);
    for (int k = 0; k < 400; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      step("R3 random", rv[0], rv[1] & rv[2], rv[3] & rv[4] & rv[5], rv[6], rv[7] & rv[8],
           {16'h0, rv[31:18], 2'b00}, rv[9] & rv[10] & rv[11], rv[13:12], {20'h0, rv[31:20]});
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule